// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block steps a macro processor's program counter through instruction memory. Each cycle that the sequencer is running, it presents an address on `pc_o` and raises `instr_valid_o`. The instruction fields read from that address come back combinationally in the same cycle. Decoding and execution stay outside the block. The sequencer only uses the fields that affect control flow: a branch flag, an exit flag, an annul flag, a condition-polarity flag, a signed word offset, and the value of the branch's source register.

A conditional branch tests its source register for zero or for nonzero. If the branch is taken and not annulled, the next sequential instruction runs first as a delay slot, and control then moves to the target. If the branch is taken and annulled, control moves straight to the target. An instruction carrying the exit flag also gets one delay slot, and the run ends after that slot. A branch found inside a delay slot is illegal. The block flags it on `slot_err_o` and treats it as not taken. A one-cycle `done_o` pulse marks the end of the run.

Top module: `dslot_sequencer`

## Requirements
- R1: A `start_i` pulse sets the PC to 0 at that edge, raises `instr_valid_o` from the next cycle, and clears any pending slot, target or exit. The slot and error outputs are then low.
- R2: After a non-branch instruction that is not in a delay slot, the PC advances by one.
- R3: The branch condition uses the polarity flag. With `instr_cond_nz_i`=0 the branch is taken when `src_val_i` is zero. With `instr_cond_nz_i`=1 it is taken when `src_val_i` is nonzero.
- R4: A taken, non-annulled branch at PC p is followed by p+1 with `slot_o`=1. The instruction after that is at the target. The target is p plus the sign-extended `instr_offset_i`, taken modulo 2^PC_W.
- R5: A taken, annulled branch is followed directly by its target, with `slot_o`=0.
- R6: A branch that is not taken continues to PC+1 with `slot_o`=0.
- R7: An exit instruction lets exactly one further instruction run, with `slot_o`=1. In the cycle after that instruction, `done_o` is high for one cycle and `instr_valid_o` is low.
- R8: A branch flag on an instruction shown with `slot_o`=1 raises `slot_err_o` in that same cycle. That branch is treated as not taken, and the slot resolves as if the branch were not there.
- R9: If one instruction carries both the exit flag and a taken, non-annulled branch, the slot at p+1 runs and then the run ends. The target is never presented.
- R10: If one instruction carries both the exit flag and a taken, annulled branch, the target runs as the exit's delay slot and then the run ends.
- R11: If the delay-slot instruction of a taken branch carries the exit flag, the target runs as that exit's slot and then the run ends.
- R12: While idle, `instr_valid_o` stays low and `pc_o` holds, whatever the instruction inputs are.
- R13: A `start_i` pulse during a run restarts the run at PC 0 and drops any pending branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin (or restart) a run at PC 0 |
| instr_branch_i | input | 1 | Current instruction is a conditional branch |
| instr_exit_i | input | 1 | Current instruction carries the exit flag |
| instr_annul_i | input | 1 | Branch annuls its delay slot when taken |
| instr_cond_nz_i | input | 1 | 0: take on zero, 1: take on nonzero |
| instr_offset_i | input | OFF_W | Signed word offset from the branch's PC |
| src_val_i | input | DATA_W | Value of the branch source register |
| pc_o | output | PC_W | Current instruction address |
| instr_valid_o | output | 1 | Instruction at `pc_o` executes this cycle |
| slot_o | output | 1 | Current instruction is a delay slot |
| slot_err_o | output | 1 | Branch found in a delay slot |
| done_o | output | 1 | One-cycle pulse after the final instruction |

## Verification
Several control decisions can fall on the same instruction. An exit flag can combine with a taken branch, either annulled or not. An exit flag can sit on a branch's delay slot. An illegal branch inside a slot can coincide with that slot resolving to its pending target. Short programs place each combination on one instruction address. The bench then judges the exact PC and slot trace, and the cycle of the done pulse, against the sequences that R8 to R11 require. In each case the bench checks that a target which should be dropped is never presented.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  // Why the current instruction is a delay slot
  typedef enum logic [1:0] {
    SLOT_NONE   = 2'd0,
    SLOT_BRANCH = 2'd1,
    SLOT_EXIT   = 2'd2
  } slot_kind_e;

endpackage

// File: rtl/dslot_cond_eval.sv
module dslot_cond_eval #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              branch_i,
  input  logic              cond_nz_i,
  input  logic [DATA_W-1:0] src_val_i,
  output logic              take_o
);
  logic is_zero;
  assign is_zero = (src_val_i == '0);
  assign take_o  = branch_i & (cond_nz_i ? ~is_zero : is_zero);
endmodule

// File: rtl/dslot_target_gen.sv
module dslot_target_gen #(
  parameter int unsigned PC_W  = 8,
  parameter int unsigned OFF_W = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [PC_W-1:0]  pc_inc_o,
  output logic [PC_W-1:0]  target_o
);
  logic [PC_W-1:0] off_ext;

  for (genvar g = 0; g < PC_W; g++) begin : g_sext
    if (g < OFF_W) begin : g_bit
      assign off_ext[g] = offset_i[g];
    end else begin : g_sign
      assign off_ext[g] = offset_i[OFF_W-1];
    end
  end

  assign pc_inc_o = pc_i + PC_W'(1);
  assign target_o = pc_i + off_ext;
endmodule

// File: rtl/dslot_next_sel.sv
module dslot_next_sel
  import dslot_pkg::*;
#(
  parameter int unsigned PC_W = 8
) (
  input  slot_kind_e      kind_i,
  input  logic            branch_i,
  input  logic            exit_i,
  input  logic            annul_i,
  input  logic            take_i,
  input  logic [PC_W-1:0] pc_inc_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [PC_W-1:0] pend_tgt_i,
  output logic [PC_W-1:0] next_pc_o,
  output slot_kind_e      next_kind_o,
  output logic            load_tgt_o,
  output logic            stop_o,
  output logic            err_o
);
  slot_kind_e after_kind;

  always_comb begin
    after_kind  = exit_i ? SLOT_EXIT : SLOT_NONE;
    next_pc_o   = pc_inc_i;
    next_kind_o = after_kind;
    load_tgt_o  = 1'b0;
    stop_o      = 1'b0;
    err_o       = (kind_i != SLOT_NONE) & branch_i;
    unique case (kind_i)
      SLOT_EXIT: begin
        stop_o = 1'b1;
      end
      SLOT_BRANCH: begin
        // branch in slot ignored; exit on slot makes target the exit slot
        next_pc_o = pend_tgt_i;
      end
      default: begin
        if (take_i && annul_i) begin
          next_pc_o = target_i;
        end else if (take_i) begin
          load_tgt_o  = 1'b1;
          next_kind_o = exit_i ? SLOT_EXIT : SLOT_BRANCH;
        end
      end
    endcase
  end
endmodule

// File: rtl/dslot_sequencer.sv
module dslot_sequencer
  import dslot_pkg::*;
#(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              instr_branch_i,
  input  logic              instr_exit_i,
  input  logic              instr_annul_i,
  input  logic              instr_cond_nz_i,
  input  logic [OFF_W-1:0]  instr_offset_i,
  input  logic [DATA_W-1:0] src_val_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              instr_valid_o,
  output logic              slot_o,
  output logic              slot_err_o,
  output logic              done_o
);
  logic            busy_q;
  logic            done_q;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] tgt_q;
  slot_kind_e      kind_q;

  logic            take;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] next_pc;
  slot_kind_e      next_kind;
  logic            load_tgt;
  logic            stop;
  logic            err;
  logic            in_slot;

  assign in_slot = (kind_q != SLOT_NONE);

  dslot_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .branch_i  (instr_branch_i & ~in_slot),
    .cond_nz_i (instr_cond_nz_i),
    .src_val_i (src_val_i),
    .take_o    (take)
  );

  dslot_target_gen #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc_i     (pc_q),
    .offset_i (instr_offset_i),
    .pc_inc_o (pc_inc),
    .target_o (target)
  );

  dslot_next_sel #(.PC_W(PC_W)) u_sel (
    .kind_i      (kind_q),
    .branch_i    (instr_branch_i),
    .exit_i      (instr_exit_i),
    .annul_i     (instr_annul_i),
    .take_i      (take),
    .pc_inc_i    (pc_inc),
    .target_i    (target),
    .pend_tgt_i  (tgt_q),
    .next_pc_o   (next_pc),
    .next_kind_o (next_kind),
    .load_tgt_o  (load_tgt),
    .stop_o      (stop),
    .err_o       (err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pc_q   <= '0;
      tgt_q  <= '0;
      kind_q <= SLOT_NONE;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      pc_q   <= '0;
      tgt_q  <= '0;
      kind_q <= SLOT_NONE;
    end else if (busy_q) begin
      if (stop) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        kind_q <= SLOT_NONE;
      end else begin
        done_q <= 1'b0;
        pc_q   <= next_pc;
        kind_q <= next_kind;
        if (load_tgt) tgt_q <= target;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign pc_o          = pc_q;
  assign instr_valid_o = busy_q;
  assign slot_o        = busy_q & in_slot;
  assign slot_err_o    = busy_q & err;
  assign done_o        = done_q;
endmodule

// File: rtl/dslot_sequencer_chk.sv
module dslot_sequencer_chk #(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              instr_branch_i,
  input logic              instr_exit_i,
  input logic              instr_annul_i,
  input logic              instr_cond_nz_i,
  input logic [OFF_W-1:0]  instr_offset_i,
  input logic [DATA_W-1:0] src_val_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              instr_valid_o,
  input logic              slot_o,
  input logic              slot_err_o,
  input logic              done_o
);
  function automatic logic [PC_W-1:0] sext(input logic [OFF_W-1:0] v);
    logic [PC_W-1:0] r;
    for (int i = 0; i < PC_W; i++) r[i] = v[(i < OFF_W) ? i : OFF_W-1];
    return r;
  endfunction

  logic cond_met;
  assign cond_met = instr_cond_nz_i ? (src_val_i != '0) : (src_val_i == '0);

  logic head_taken;
  assign head_taken = instr_valid_o & ~slot_o & instr_branch_i & cond_met & ~start_i;

  AST_START_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pc_o == '0) && instr_valid_o && !slot_o && !slot_err_o); // R1

  AST_SLOT_AFTER_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_taken && !instr_annul_i |=> slot_o && (pc_o == $past(pc_o) + PC_W'(1))); // R4

  AST_ANNUL_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_taken && instr_annul_i |=> instr_valid_o
      && (pc_o == $past(pc_o) + sext($past(instr_offset_i)))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !instr_valid_o); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o); // R7

  AST_ERR_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_err_o |-> slot_o && instr_valid_o); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_o && !start_i |=> !instr_valid_o && $stable(pc_o)); // R12
endmodule

bind dslot_sequencer dslot_sequencer_chk #(
  .PC_W(PC_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/dslot_sequencer_bench.sv
module dslot_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 8;
  localparam int OFF_W = 8;
  localparam int DATA_W = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic instr_branch_i, instr_exit_i, instr_annul_i, instr_cond_nz_i;
  logic [OFF_W-1:0]  instr_offset_i;
  logic [DATA_W-1:0] src_val_i;
  logic [PC_W-1:0]   pc_o;
  logic instr_valid_o, slot_o, slot_err_o, done_o;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;
  int prog_sel = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dslot_sequencer #(.PC_W(PC_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dslot_sequencer (.*);

  // word: [12]branch [11]exit [10]annul [9]cond_nz [8]src_is_zero [7:0]offset
  function automatic logic [12:0] mk(bit br, bit ex, bit an, bit nz, bit z, logic [7:0] off);
    return {br, ex, an, nz, z, off};
  endfunction

  function automatic logic [12:0] prog(int sel, logic [PC_W-1:0] pc);
    logic [12:0] w = '0;
    case (sel)
      0: case (pc)
           8'd1:  w = mk(1, 0, 0, 0, 1, 8'd5);   // take on zero, slot, ->6
           8'd6:  w = mk(1, 0, 0, 1, 1, 8'd9);   // nz on zero: not taken
           8'd7:  w = mk(1, 0, 1, 1, 0, 8'd3);   // annulled taken ->10
           8'd10: w = mk(1, 0, 0, 0, 0, 8'd40);  // z on nonzero: not taken
           8'd11: w = mk(1, 0, 0, 0, 1, 8'd9);   // taken ->20
           8'd12: w = mk(1, 0, 1, 0, 1, 8'd50);  // illegal branch in slot
           8'd20: w = mk(0, 1, 0, 0, 0, 8'd0);   // exit
           default: w = '0;
         endcase
      1: if (pc == 8'd0) w = mk(1, 1, 0, 0, 1, 8'd4);
      2: if (pc == 8'd0) w = mk(1, 1, 1, 0, 1, 8'd6);
      3: case (pc)
           8'd0: w = mk(1, 0, 0, 0, 1, 8'd3);
           8'd1: w = mk(0, 1, 0, 0, 0, 8'd0);
           default: w = '0;
         endcase
      4: case (pc)
           8'd0:   w = mk(1, 0, 1, 1, 0, 8'hFC); // -4 wraps to 252
           8'd252: w = mk(0, 1, 0, 0, 0, 8'd0);
           default: w = '0;
         endcase
      default: w = '0;
    endcase
    return w;
  endfunction

  logic [12:0] cur;
  always_comb begin
    cur = prog(prog_sel, pc_o);
    instr_branch_i  = cur[12];
    instr_exit_i    = cur[11];
    instr_annul_i   = cur[10];
    instr_cond_nz_i = cur[9];
    instr_offset_i  = cur[7:0];
    src_val_i       = cur[8] ? '0 : 32'h0000_5A00;
  end

  // main trace: {pc, slot, err}
  localparam logic [9:0] TRACE [10] = '{
    {8'd0, 1'b0, 1'b0}, {8'd1, 1'b0, 1'b0}, {8'd2, 1'b1, 1'b0}, {8'd6, 1'b0, 1'b0},
    {8'd7, 1'b0, 1'b0}, {8'd10, 1'b0, 1'b0}, {8'd11, 1'b0, 1'b0}, {8'd12, 1'b1, 1'b1},
    {8'd20, 1'b0, 1'b0}, {8'd21, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic kick(int sel);
    prog_sel = sel;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic step(string req, int pc, bit slot);
    check({req, " valid"}, 32'(instr_valid_o), 32'd1);
    check({req, " pc"}, 32'(pc_o), 32'(pc));
    check({req, " slot"}, 32'(slot_o), 32'(slot));
    @(negedge clk_i);
  endtask

  task automatic expect_done(string req);
    check({req, " done"}, 32'(done_o), 32'd1);
    check({req, " valid low"}, 32'(instr_valid_o), 32'd0);
    @(negedge clk_i);
    check({req, " done single"}, 32'(done_o), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual expired expected completion");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 / R12: reset state idle
    check("R1 reset valid", 32'(instr_valid_o), 32'd0);
    check("R1 reset pc", 32'(pc_o), 32'd0);
    check("R1 reset done", 32'(done_o), 32'd0);

    // R2 R3 R4 R6 R8: main trace table
    kick(0);
    for (int i = 0; i < 10; i++) begin
      check("R2_R3_R4_R6 trace valid", 32'(instr_valid_o), 32'd1);
      check("R2_R3_R4_R6 trace pc", 32'(pc_o), 32'(TRACE[i][9:2]));
      check("R4_R5 trace slot", 32'(slot_o), 32'(TRACE[i][1]));
      check("R8 trace slot_err", 32'(slot_err_o), 32'(TRACE[i][0]));
      @(negedge clk_i);
    end
    expect_done("R7 main exit");

    // R12: idle holds PC
    repeat (3) @(negedge clk_i);
    check("R12 idle valid", 32'(instr_valid_o), 32'd0);
    check("R12 idle pc", 32'(pc_o), 32'd21);

    // R9: exit + taken non-annulled branch
    kick(1);
    step("R9 head", 0, 0);
    step("R9 slot", 1, 1);
    expect_done("R9");

    // R10: exit + annulled taken branch
    kick(2);
    step("R10 head", 0, 0);
    step("R10 target as slot", 6, 1);
    expect_done("R10");

    // R11: exit on branch delay slot
    kick(3);
    step("R11 head", 0, 0);
    step("R11 slot", 1, 1);
    step("R11 target as exit slot", 3, 1);
    expect_done("R11");

    // R4 / R5: negative offset wraps
    kick(4);
    step("R5 head", 0, 0);
    step("R5 R4 wrapped target", 252, 0);
    step("R7 exit slot", 253, 1);
    expect_done("R7 wrap");

    // R13: restart mid-run while a target is pending
    kick(0);
    step("R13 pre", 0, 0);
    step("R13 pre", 1, 0);
    check("R13 in slot", 32'(slot_o), 32'd1);
    start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    step("R13 restarted", 0, 0);
    step("R13 restarted", 1, 0);
    step("R13 restarted slot", 2, 1);
    step("R13 target", 6, 0);
    for (int i = 0; i < 20 && !done_o; i++) @(negedge clk_i);
    check("R13 completes", 32'(done_o), 32'd1);

    summary();
  end
endmodule